// File: doc/BRIEF.md
# LIN Slave Header Detector

This block sits on the receive path of a LIN slave node and watches the serial line for the start of a new frame. It samples the line 16 times per bit and recognises the three header fields in their fixed order: a long dominant break, a sync byte of 0x55 and an identifier byte. While it waits for a header the receiver is muted, so no data bytes are reported. When a header completes cleanly at the end of the identifier stop bit, the block leaves mute, presents the identifier and raises its header-detected and data-ready flags.

A header-length timer starts at the falling edge that opens the break. If 57 bit times pass before the header completes, a header error is reported and the receiver stays muted. This holds even when the limit falls inside the last samples of the identifier stop bit. In that case the timeout wins outright: no wakeup, no data-ready flag and no second interrupt. Software clears flags with a two-step access, a status read followed by a data read. The interrupt line is the OR of the flags that are enabled.

Top module: `lhd_header_detect`

## Requirements
- R1: Each bit takes 16 sample ticks. Sample 0 is the tick that first sees the falling edge. The bit value is the majority of samples 7, 8 and 9. A byte frame is a low start bit, then 8 data bits LSB first, then a high stop bit.
- R2: A break is accepted when the line returns high after at least 176 low samples (11 bits). A shorter low period is dropped and changes no flag, no mute state and no identifier.
- R3: After the break, the sync byte must decode to 0x55 with a valid start and stop bit, and the identifier must have a valid start and stop bit. Any violation sets the error flag and mutes the receiver. The header-detected and data-ready flags are not set and the identifier output keeps its value.
- R4: A valid header takes effect on sample 15 of the identifier stop bit. Mute is cleared, the header-detected and data-ready flags are set, and the identifier byte appears on `id_o`.
- R5: The header timer counts sample ticks from the break's sample 0. When it reaches sample 912 (57 bits) before the header has completed, the error flag is set and the receiver stays muted. This includes a break that is still low at that point.
- R6: If the timeout falls on the same sample as the identifier completion, or on any earlier sample of the stop bit, the timeout wins. Mute stays set, the data-ready and header-detected flags stay clear, and the identifier is unchanged.
- R7: A data read clears exactly the flags that were set at the most recent status read. A data read with no status read before it clears nothing. A flag set after the status read survives the data read. A new set wins over a clear in the same cycle.
- R8: `irq_o` is high when any flag is set and its enable bit is set. Enable bit 0 gates header-detected, bit 1 gates error and bit 2 gates data-ready.
- R9: A synchronous active-low reset returns the receiver to mute, clears every flag and the identifier, and holds the interrupt low.
- R10: An accepted break sets mute again, even when a previous header had woken the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| rx_i | input | 1 | Serial line, low is dominant |
| rd_status_i | input | 1 | Status register read pulse |
| rd_data_i | input | 1 | Data register read pulse |
| ie_i | input | 3 | Interrupt enables: 0 header, 1 error, 2 data-ready |
| id_o | output | 8 | Last accepted identifier byte |
| muted_o | output | 1 | Receiver mute state |
| hdr_o | output | 1 | Header-detected flag |
| err_o | output | 1 | Header error flag |
| rdy_o | output | 1 | Data-ready flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters (16 samples per bit, an 11-bit break minimum and a 57-bit limit) and holds the tick high on every clock. One bit is then 16 clocks, so moving the break-to-sync gap one clock at a time places the timeout on each sample of the identifier stop bit. The outcome of each placement follows from plain arithmetic on the header length. The same setting lets the bench hit the break threshold at exactly 175 and 176 low samples, and flip one or two of the three majority samples.

// File: rtl/lhd_pkg.sv
// Shared types for the LIN slave header detector.
// Assumes: a single clock domain; all users import this package.
package lhd_pkg;

    // Header receive sequence
    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,   // idle, looking for a break falling edge
        ST_BREAK = 3'd1,   // line low, measuring break length
        ST_SWAIT = 3'd2,   // waiting for the sync start bit
        ST_SYNC  = 3'd3,   // receiving the sync byte
        ST_IWAIT = 3'd4,   // waiting for the identifier start bit
        ST_ID    = 3'd5    // receiving the identifier byte
    } hdr_state_e;

    // Flag vector positions, also the enable bit positions
    localparam int FLG_HDR = 0;
    localparam int FLG_ERR = 1;
    localparam int FLG_RDY = 2;
    localparam int NUM_FLG = 3;

endpackage

// File: rtl/lhd_rx_front.sv
// Line front end: synchronises the raw serial input and detects falling
// edges between consecutive oversampling ticks.
// Assumes: rx_i is asynchronous; tick_i is a one-clock strobe.
module lhd_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   samp_q;

    // Metastability chain, idle level high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end

    assign rx_s_o = sync_q[SYNC_STAGES-1];

    // Line level seen at the previous tick
    always_ff @(posedge clk) begin
        if (!rst_n)      samp_q <= 1'b1;
        else if (tick_i) samp_q <= rx_s_o;
    end

    assign fall_o = tick_i & samp_q & ~rx_s_o;

endmodule

// File: rtl/lhd_frame_rx.sv
// Byte frame receiver: start bit, DATA_W data bits LSB first, stop bit.
// Each bit is a majority vote over the three samples around mid-bit.
// Assumes: start_i coincides with the tick holding sample 0 of the start bit.
module lhd_frame_rx #(
    parameter int OSR    = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_s_i,
    input  logic              start_i,
    input  logic              abort_i,
    output logic              last_o,
    output logic              ok_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int FRAME_BITS = DATA_W + 2;
    localparam int PH_W       = $clog2(OSR);
    localparam int BI_W       = $clog2(FRAME_BITS);
    localparam int MID        = OSR / 2;
    localparam logic [PH_W-1:0] PH_S0   = PH_W'(MID - 1);
    localparam logic [PH_W-1:0] PH_S1   = PH_W'(MID);
    localparam logic [PH_W-1:0] PH_DEC  = PH_W'(MID + 1);
    localparam logic [PH_W-1:0] PH_END  = PH_W'(OSR - 1);
    localparam logic [BI_W-1:0] BI_STOP = BI_W'(FRAME_BITS - 1);

    logic              busy_q;
    logic [PH_W-1:0]   phase_q;
    logic [BI_W-1:0]   bit_q;
    logic              s0_q, s1_q;
    logic              start_ok_q, stop_ok_q;
    logic [DATA_W-1:0] data_q;
    logic              maj;

    // Two of three samples decide the bit
    always_comb maj = (s0_q & s1_q) | (s0_q & rx_s_i) | (s1_q & rx_s_i);

    assign last_o = busy_q & tick_i & (phase_q == PH_END) & (bit_q == BI_STOP);
    assign ok_o   = start_ok_q & stop_ok_q;
    assign data_o = data_q;

    // Bit timing, sample capture and byte assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            phase_q    <= '0;
            bit_q      <= '0;
            s0_q       <= 1'b1;
            s1_q       <= 1'b1;
            start_ok_q <= 1'b0;
            stop_ok_q  <= 1'b0;
            data_q     <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
        end else if (start_i) begin
            busy_q  <= 1'b1;
            phase_q <= PH_W'(1);
            bit_q   <= '0;
        end else if (busy_q && tick_i) begin
            phase_q <= (phase_q == PH_END) ? '0 : phase_q + 1'b1;
            if (phase_q == PH_S0) s0_q <= rx_s_i;
            if (phase_q == PH_S1) s1_q <= rx_s_i;
            if (phase_q == PH_DEC) begin
                if (bit_q == '0)           start_ok_q <= ~maj;
                else if (bit_q == BI_STOP) stop_ok_q  <= maj;
                else                       data_q     <= {maj, data_q[DATA_W-1:1]};
            end
            if (phase_q == PH_END) begin
                if (bit_q == BI_STOP) busy_q <= 1'b0;
                else                  bit_q  <= bit_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lhd_hdr_timer.sv
// Header length timer: counts ticks from the break's first low sample
// and flags expiry combinationally on the limit tick.
// Assumes: start_i and stop_i are never high together.
module lhd_hdr_timer #(
    parameter int LIMIT = 912,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expired_o
);

    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    assign cnt_o     = cnt_q;
    assign expired_o = run_q & tick_i & (cnt_q == LIM_C);

    // Run control and tick counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (stop_i || expired_o) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(1);
        end else if (run_q && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lhd_flags.sv
// Event flags with a two-step clear: a status read arms the flags that are
// set at that moment, the following data read clears only those.
// Assumes: set pulses are single-cycle; a set wins over a clear.
module lhd_flags #(
    parameter int NFLG = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLG-1:0] set_i,
    input  logic            rd_status_i,
    input  logic            rd_data_i,
    input  logic [NFLG-1:0] ie_i,
    output logic [NFLG-1:0] flag_o,
    output logic            irq_o
);

    logic [NFLG-1:0] flag_q;
    logic [NFLG-1:0] arm_q;

    for (genvar g = 0; g < NFLG; g++) begin : g_flag
        // One flag and its clear-arm bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
                arm_q[g]  <= 1'b0;
            end else begin
                flag_q[g] <= set_i[g] | (flag_q[g] & ~(rd_data_i & arm_q[g]));
                if (rd_status_i)    arm_q[g] <= flag_q[g];
                else if (rd_data_i) arm_q[g] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = |(flag_q & ie_i);

endmodule

// File: rtl/lhd_header_detect.sv
// LIN slave header detector top. Sequences break, sync and identifier,
// owns the mute state and the identifier register. A header timeout is
// resolved before completion in the same tick, so it always keeps mute.
// Assumes: tick_i is a 16x bit-rate strobe; software reads are pulses.
module lhd_header_detect
    import lhd_pkg::*;
#(
    parameter int          OSR      = 16,
    parameter int          BRK_BITS = 11,
    parameter int          TMO_BITS = 57,
    parameter logic [7:0]  SYNC_VAL = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic       rd_status_i,
    input  logic       rd_data_i,
    input  logic [2:0] ie_i,
    output logic [7:0] id_o,
    output logic       muted_o,
    output logic       hdr_o,
    output logic       err_o,
    output logic       rdy_o,
    output logic       irq_o
);

    localparam int TMO_TICKS = TMO_BITS * OSR;
    localparam int CNT_W     = $clog2(TMO_TICKS + 1);
    localparam logic [CNT_W-1:0] BRK_C = CNT_W'(BRK_BITS * OSR);

    hdr_state_e         state_q, state_d;
    logic               rx_s, fall;
    logic               tmr_start, tmr_stop, tmo;
    logic [CNT_W-1:0]   tmr_cnt;
    logic               frm_start, frm_abort, frm_last, frm_ok;
    logic [7:0]         frm_data;
    logic               hdr_ok, hdr_err, brk_ok;
    logic               mute_q;
    logic [7:0]         id_q;
    logic [NUM_FLG-1:0] flag_set, flags;

    lhd_rx_front #(.SYNC_STAGES(2)) u_front (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_i(rx_i),
        .rx_s_o(rx_s), .fall_o(fall)
    );

    lhd_hdr_timer #(.LIMIT(TMO_TICKS), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .start_i(tmr_start), .stop_i(tmr_stop),
        .cnt_o(tmr_cnt), .expired_o(tmo)
    );

    lhd_frame_rx #(.OSR(OSR), .DATA_W(8)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rx_s_i(rx_s),
        .start_i(frm_start), .abort_i(frm_abort),
        .last_o(frm_last), .ok_o(frm_ok), .data_o(frm_data)
    );

    // Header sequencing; timeout is tested ahead of every completion
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        tmr_stop  = 1'b0;
        frm_start = 1'b0;
        frm_abort = 1'b0;
        hdr_ok    = 1'b0;
        hdr_err   = 1'b0;
        brk_ok    = 1'b0;
        case (state_q)
            ST_WAIT: begin
                if (fall) begin
                    tmr_start = 1'b1;
                    state_d   = ST_BREAK;
                end
            end
            ST_BREAK: begin
                if (tmo) begin
                    hdr_err = 1'b1;
                end else if (tick_i && rx_s) begin
                    if (tmr_cnt >= BRK_C) begin
                        brk_ok  = 1'b1;
                        state_d = ST_SWAIT;
                    end else begin
                        tmr_stop = 1'b1;
                        state_d  = ST_WAIT;
                    end
                end
            end
            ST_SWAIT, ST_IWAIT: begin
                if (tmo) begin
                    hdr_err = 1'b1;
                end else if (fall) begin
                    frm_start = 1'b1;
                    state_d   = (state_q == ST_SWAIT) ? ST_SYNC : ST_ID;
                end
            end
            ST_SYNC: begin
                if (tmo) begin
                    hdr_err = 1'b1;
                end else if (frm_last) begin
                    if (frm_ok && frm_data == SYNC_VAL) state_d = ST_IWAIT;
                    else                                hdr_err = 1'b1;
                end
            end
            ST_ID: begin
                if (tmo) begin
                    hdr_err = 1'b1;
                end else if (frm_last) begin
                    if (frm_ok) hdr_ok  = 1'b1;
                    else        hdr_err = 1'b1;
                end
            end
            default: state_d = ST_WAIT;
        endcase
        if (hdr_ok || hdr_err) begin
            state_d   = ST_WAIT;
            tmr_stop  = 1'b1;
            frm_abort = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Mute: cleared only by a completed header, set by break or error
    always_ff @(posedge clk) begin
        if (!rst_n)                 mute_q <= 1'b1;
        else if (hdr_ok)            mute_q <= 1'b0;
        else if (hdr_err || brk_ok) mute_q <= 1'b1;
    end

    // Identifier capture on completion
    always_ff @(posedge clk) begin
        if (!rst_n)      id_q <= '0;
        else if (hdr_ok) id_q <= frm_data;
    end

    always_comb begin
        flag_set          = '0;
        flag_set[FLG_HDR] = hdr_ok;
        flag_set[FLG_ERR] = hdr_err;
        flag_set[FLG_RDY] = hdr_ok;
    end

    lhd_flags #(.NFLG(NUM_FLG)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(flag_set),
        .rd_status_i(rd_status_i), .rd_data_i(rd_data_i), .ie_i(ie_i),
        .flag_o(flags), .irq_o(irq_o)
    );

    assign id_o    = id_q;
    assign muted_o = mute_q;
    assign hdr_o   = flags[FLG_HDR];
    assign err_o   = flags[FLG_ERR];
    assign rdy_o   = flags[FLG_RDY];

endmodule

// File: rtl/lhd_hdr_checker.sv
// Port-level properties of the header detector, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module lhd_hdr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_data_i,
    input logic [7:0] id_o,
    input logic       muted_o,
    input logic       hdr_o,
    input logic       err_o,
    input logic       rdy_o,
    input logic       irq_o
);

    AST_WAKE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(muted_o) |-> (hdr_o && rdy_o));                        // R4

    AST_RDY_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $fell(muted_o));                            // R6

    AST_ERR_KEEPS_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (muted_o && !$rose(rdy_o)));                // R5

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(err_o) || $fell(hdr_o) || $fell(rdy_o)) |-> $past(rd_data_i)); // R7

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (hdr_o || err_o || rdy_o));                        // R8

    AST_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(muted_o) |-> $stable(id_o));                          // R3

endmodule

bind lhd_header_detect lhd_hdr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data_i), .id_o(id_o),
    .muted_o(muted_o), .hdr_o(hdr_o), .err_o(err_o), .rdy_o(rdy_o),
    .irq_o(irq_o)
);

// File: tb/sim_lhd_header_detect.sv
// Bench for the header detector with defaults; tick held high, so a bit is
// 16 clocks and every sample position can be reached by clock offsets.
module sim_lhd_header_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rx = 1'b1;
    logic       rd_st = 1'b0;
    logic       rd_dt = 1'b0;
    logic [2:0] ie = 3'b000;
    logic [7:0] id;
    logic       muted, hdr, err, rdy, irq;
    int         total = 0;
    int         bad = 0;
    logic [7:0] id_exp = 8'h00;

    always #4 clk = ~clk;

    lhd_header_detect u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx),
        .rd_status_i(rd_st), .rd_data_i(rd_dt), .ie_i(ie),
        .id_o(id), .muted_o(muted), .hdr_o(hdr), .err_o(err),
        .rdy_o(rdy), .irq_o(irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic st(string req, int m, int h, int e, int r);
        chk(req, "muted", int'(muted), m);
        chk(req, "hdr", int'(hdr), h);
        chk(req, "err", int'(err), e);
        chk(req, "rdy", int'(rdy), r);
        chk(req, "id", int'(id), int'(id_exp));
    endtask

    task automatic level(logic v, int n);
        for (int i = 0; i < n; i++) begin
            rx = v;
            @(negedge clk);
        end
    endtask

    task automatic frame(logic [7:0] v, logic stp, int gpos, int glen);
        for (int c = 0; c < 160; c++) begin
            int   b;
            logic val;
            b = c / 16;
            if (b == 0)      val = 1'b0;
            else if (b == 9) val = stp;
            else             val = v[b-1];
            if (c >= gpos && c < gpos + glen) val = ~val;
            rx = val;
            @(negedge clk);
        end
    endtask

    task automatic header(int low, int gap, logic [7:0] sv, logic sstp,
                          logic [7:0] iv, logic istp, int gpos, int glen);
        level(1'b0, low);
        level(1'b1, gap);
        frame(sv, sstp, gpos, glen);
        frame(iv, istp, -1, 0);
        level(1'b1, 12);
    endtask

    task automatic rd_clear();
        rd_st = 1'b1; @(negedge clk); rd_st = 1'b0;
        rd_dt = 1'b1; @(negedge clk); rd_dt = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        st("R9", 1, 0, 0, 0);
        chk("R9", "irq", int'(irq), 0);

        // R3 R4: clean header with 13-bit break
        header(208, 16, 8'h55, 1'b1, 8'h3A, 1'b1, -1, 0);
        id_exp = 8'h3A;
        st("R4", 0, 1, 0, 1);

        // R8: every enable pattern with header and ready flags set
        for (int e = 0; e < 8; e++) begin
            ie = 3'(e);
            @(negedge clk);
            chk("R8", "irq", int'(irq), (e & 3'b101) != 0 ? 1 : 0);
        end

        // R7: data read alone clears nothing, then the full sequence clears
        rd_dt = 1'b1; @(negedge clk); rd_dt = 1'b0; @(negedge clk);
        st("R7", 0, 1, 0, 1);
        rd_clear();
        st("R7", 0, 0, 0, 0);
        chk("R7", "irq", int'(irq), 0);

        // R2: 175 low samples is no break; 176 is
        header(175, 16, 8'h55, 1'b1, 8'h11, 1'b1, -1, 0);
        st("R2", 0, 0, 0, 0);
        header(176, 16, 8'h55, 1'b1, 8'h12, 1'b1, -1, 0);
        id_exp = 8'h12;
        st("R2", 0, 1, 0, 1);
        rd_clear();

        // R10: accepted break mutes an active receiver
        level(1'b0, 208);
        level(1'b1, 16);
        chk("R10", "muted", int'(muted), 1);
        frame(8'h55, 1'b1, -1, 0);
        frame(8'h21, 1'b1, -1, 0);
        level(1'b1, 12);
        id_exp = 8'h21;
        st("R10", 0, 1, 0, 1);
        rd_clear();

        // R3: wrong sync value, bad sync stop, bad identifier stop
        header(208, 16, 8'h54, 1'b1, 8'h22, 1'b1, -1, 0);
        st("R3", 1, 0, 1, 0);
        rd_clear();
        header(208, 16, 8'h55, 1'b0, 8'h23, 1'b1, -1, 0);
        st("R3", 1, 0, 1, 0);
        rd_clear();
        header(208, 16, 8'h55, 1'b1, 8'h24, 1'b0, -1, 0);
        st("R3", 1, 0, 1, 0);
        rd_clear();

        // R1: one bad sample of three is outvoted, two flip the bit
        header(208, 16, 8'h55, 1'b1, 8'h44, 1'b1, 24, 1);
        id_exp = 8'h44;
        st("R1", 0, 1, 0, 1);
        rd_clear();
        header(208, 16, 8'h55, 1'b1, 8'h45, 1'b1, 23, 2);
        st("R1", 1, 0, 1, 0);
        rd_clear();

        // R5: break held past the limit
        level(1'b0, 58 * 16);
        st("R5", 1, 0, 1, 0);
        level(1'b1, 20);
        ie = 3'b010; @(negedge clk);
        chk("R8", "irq err enabled", int'(irq), 1);
        ie = 3'b101; @(negedge clk);
        chk("R8", "irq err masked", int'(irq), 0);

        // R7: flags set after the status read survive the data read
        rd_st = 1'b1; @(negedge clk); rd_st = 1'b0;
        header(208, 16, 8'h55, 1'b1, 8'h66, 1'b1, -1, 0);
        id_exp = 8'h66;
        rd_dt = 1'b1; @(negedge clk); rd_dt = 1'b0; @(negedge clk);
        st("R7", 0, 1, 0, 1);
        rd_clear();

        // R5 R6: slide completion across the limit, one sample per step
        for (int d = 376; d <= 392; d++) begin
            logic [7:0] iv;
            bit         good;
            iv   = 8'(8'h80 + d - 376);
            good = (208 + d + 319) < 912;
            header(208, d, 8'h55, 1'b1, iv, 1'b1, -1, 0);
            if (good) begin
                id_exp = iv;
                st("R5", 0, 1, 0, 1);
            end else begin
                st("R6", 1, 0, 1, 0);
            end
            rd_clear();
            chk("R6", "irq after clear", int'(irq), 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule